// File: doc/BRIEF.md
# Per-Cycle Cache Port Limiter

This block sits between a load/store queue and a data cache. Every cycle the queue presents a set of load lanes and a set of store lanes that want to reach the cache. The block grants lanes in ascending lane order, and loads and stores draw on separate per-cycle budgets. Nothing is carried over from one cycle to the next: each clock edge starts a fresh count for both types. The cache answers each granted lane with an accept or reject bit in the same cycle. Accepted sends are counted. A rejected send is not counted, and it puts the block into a blocked state in which nothing is granted until the cache signals that it can take traffic again.

When the loads accepted in a cycle use the whole load budget and the cache stays unblocked, the block raises a one-cycle replay pulse in the following cycle. This tells the issue stage to retry loads that were refused for lack of a port.

In total-store-order mode, store traffic is serialised. No store is granted while an earlier store is still in flight, and at most one store is granted per cycle. A store-blocked flag records whether the most recent store attempt was rejected.

Top module: `cache_port_limiter`

## Requirements
- R1: A load lane is granted only if it is requesting. Requesting lanes are granted from lane 0 upward, and a lane is granted only while fewer than LD_BUDGET lower lanes have been granted in the same cycle (bit i of each lane vector is lane i).
- R2: While cache_blocked is high, no load or store lane is granted.
- R3: The number of load grants in a cycle never exceeds LD_BUDGET, and the number of store grants never exceeds ST_BUDGET. The two budgets are independent of each other.
- R4: Only lanes that are both granted and accepted are counted. The count starts from zero in every cycle, so the full budget is available again in the next cycle.
- R5: If any granted lane is rejected (its accept bit is 0), cache_blocked is high from the next cycle. This holds even if cache_unblock is asserted in the same cycle.
- R6: While blocked, asserting cache_unblock clears cache_blocked at the next clock edge. The clear is not visible in the cycle in which cache_unblock is asserted.
- R7: replay is high for exactly the cycle after a cycle in which the number of accepted loads equals LD_BUDGET and no granted lane was rejected. In every other cycle it is low.
- R8: With tso_en high, no store is granted while st_inflight is high, and at most one store (the lowest requesting lane) is granted per cycle. With tso_en low, st_inflight is ignored.
- R9: st_blocked is set after a cycle in which a granted store was rejected. It is cleared after a cycle with an accepted store and no rejected store. Otherwise it holds its value.
- R10: A synchronous active-high reset clears cache_blocked, replay and st_blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | NUM_LD | Load lanes requesting a cache send |
| st_req | input | NUM_ST | Store lanes requesting a cache send |
| tso_en | input | 1 | Total-store-order mode |
| st_inflight | input | 1 | An earlier store is still in flight |
| ld_acc | input | NUM_LD | Cache accept bit per granted load lane |
| st_acc | input | NUM_ST | Cache accept bit per granted store lane |
| cache_unblock | input | 1 | Cache can accept traffic again |
| ld_gnt | output | NUM_LD | Load lanes sent to the cache this cycle |
| st_gnt | output | NUM_ST | Store lanes sent to the cache this cycle |
| cache_blocked | output | 1 | Cache rejected a send and has not yet unblocked |
| replay | output | 1 | Reissue refused loads |
| st_blocked | output | 1 | Last store attempt was rejected |

## Verification
The bench builds the block with four load lanes and two store lanes, and with budgets of two loads and two stores instead of the large defaults. With the small budgets, one cycle of requests can exhaust a budget, so the bench can see lanes above the cut being dropped and can provoke the replay pulse. A store budget of two also lets the one-store-per-cycle rule of total-store-order mode be told apart from the budget limit. A reject combined with a full load budget, and a reject in the same cycle as an unblock, are both driven to confirm the priority rules.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 1) ? 1 : $clog2(maxv + 1);
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cpl_lane_grant.sv
// Ascending-order lane grant capped by a per-cycle budget.
module cpl_lane_grant #(
  parameter int LANES  = 4,
  parameter int BUDGET = 200
) (
  input  logic [LANES-1:0] req,
  input  logic             en,
  input  logic             single,
  output logic [LANES-1:0] gnt
);
  always_comb begin
    int taken;
    taken = 0;
    gnt   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (en && req[i] && (taken < BUDGET) && (!single || taken == 0)) begin
        gnt[i] = 1'b1;
        taken  = taken + 1;
      end
    end
  end
endmodule

// File: rtl/cpl_use_count.sv
// Counts accepted sends of one type within the current cycle.
module cpl_use_count
  import cpl_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BUDGET = 200,
  localparam int UW    = cnt_width(max_u(BUDGET, LANES))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] gnt,
  input  logic [LANES-1:0] acc,
  output logic [UW-1:0]    used_now,
  output logic             any_rej,
  output logic             any_ok
);
  logic [LANES-1:0] sent;
  logic [LANES-1:0] refused;
  logic [UW-1:0]    used_q;

  assign sent    = gnt & acc;
  assign refused = gnt & ~acc;
  assign any_rej = |refused;
  assign any_ok  = |sent;

  always_comb begin
    used_now = '0;
    for (int i = 0; i < LANES; i++) begin
      used_now = used_now + UW'(sent[i]);
    end
  end

  // Snapshot of the finished cycle; the live count restarts every edge.
  always_ff @(posedge clk) begin
    if (rst) used_q <= '0;
    else     used_q <= used_now;
  end

  // R4: a used count never exceeds its budget
  a_r4_used_cap: assert property (@(posedge clk) disable iff (rst)
    used_q <= UW'(BUDGET));
endmodule

// File: rtl/cache_port_limiter.sv
module cache_port_limiter
  import cpl_pkg::*;
#(
  parameter int NUM_LD    = 4,
  parameter int NUM_ST    = 2,
  parameter int LD_BUDGET = 200,
  parameter int ST_BUDGET = 200,
  localparam int LD_UW    = cnt_width(max_u(LD_BUDGET, NUM_LD)),
  localparam int ST_UW    = cnt_width(max_u(ST_BUDGET, NUM_ST))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_LD-1:0] ld_req,
  input  logic [NUM_ST-1:0] st_req,
  input  logic              tso_en,
  input  logic              st_inflight,
  input  logic [NUM_LD-1:0] ld_acc,
  input  logic [NUM_ST-1:0] st_acc,
  input  logic              cache_unblock,
  output logic [NUM_LD-1:0] ld_gnt,
  output logic [NUM_ST-1:0] st_gnt,
  output logic              cache_blocked,
  output logic              replay,
  output logic              st_blocked
);
  logic             blk_q, rep_q, sb_q;
  logic             ld_en, st_en;
  logic [LD_UW-1:0] ld_used;
  logic [ST_UW-1:0] st_used;
  logic             ld_rej, st_rej, ld_ok, st_ok;
  logic             any_rej;

  assign ld_en = !blk_q;
  assign st_en = !blk_q && !(tso_en && st_inflight);

  cpl_lane_grant #(.LANES(NUM_LD), .BUDGET(LD_BUDGET)) u_ld_grant (
    .req(ld_req), .en(ld_en), .single(1'b0), .gnt(ld_gnt));

  cpl_lane_grant #(.LANES(NUM_ST), .BUDGET(ST_BUDGET)) u_st_grant (
    .req(st_req), .en(st_en), .single(tso_en), .gnt(st_gnt));

  cpl_use_count #(.LANES(NUM_LD), .BUDGET(LD_BUDGET)) u_ld_count (
    .clk(clk), .rst(rst), .gnt(ld_gnt), .acc(ld_acc),
    .used_now(ld_used), .any_rej(ld_rej), .any_ok(ld_ok));

  cpl_use_count #(.LANES(NUM_ST), .BUDGET(ST_BUDGET)) u_st_count (
    .clk(clk), .rst(rst), .gnt(st_gnt), .acc(st_acc),
    .used_now(st_used), .any_rej(st_rej), .any_ok(st_ok));

  assign any_rej = ld_rej || st_rej;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= 1'b0;
      rep_q <= 1'b0;
      sb_q  <= 1'b0;
    end else begin
      blk_q <= (blk_q && !cache_unblock) || any_rej;
      rep_q <= (ld_used == LD_UW'(LD_BUDGET)) && !any_rej;
      if (st_rej)     sb_q <= 1'b1;
      else if (st_ok) sb_q <= 1'b0;
    end
  end

  assign cache_blocked = blk_q;
  assign replay        = rep_q;
  assign st_blocked    = sb_q;

  // R1: grants only on requesting lanes
  a_r1_ld_subset: assert property (@(posedge clk) disable iff (rst)
    (ld_gnt & ~ld_req) == '0);
  // R2: silent while blocked
  a_r2_quiet_blocked: assert property (@(posedge clk) disable iff (rst)
    cache_blocked |-> (ld_gnt == '0 && st_gnt == '0));
  // R3: per-type caps
  a_r3_ld_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(ld_gnt) <= LD_BUDGET);
  a_r3_st_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(st_gnt) <= ST_BUDGET);
  // R5: a rejected send blocks the cache
  a_r5_reject_blocks: assert property (@(posedge clk) disable iff (rst)
    (|(ld_gnt & ~ld_acc) || |(st_gnt & ~st_acc)) |=> cache_blocked);
  // R6: unblock clears the flag
  a_r6_unblock: assert property (@(posedge clk) disable iff (rst)
    (cache_blocked && cache_unblock) |=> !cache_blocked);
  // R7: replay only while unblocked
  a_r7_replay_open: assert property (@(posedge clk) disable iff (rst)
    replay |-> !cache_blocked);
  // R8: store ordering gate
  a_r8_tso_wait: assert property (@(posedge clk) disable iff (rst)
    (tso_en && st_inflight) |-> st_gnt == '0);
  a_r8_tso_single: assert property (@(posedge clk) disable iff (rst)
    tso_en |-> $countones(st_gnt) <= 1);
endmodule

// File: tb/cache_port_limiter_test.sv
module cache_port_limiter_test;
  localparam int NLD = 4;
  localparam int NST = 2;
  localparam int NV  = 16;
  // fields: ldr[23:20] str[19:18] tso[17] infl[16] lda[15:12] sta[11:10]
  //         unb[9] exp_ld_gnt[8:5] exp_st_gnt[4:3] exp_blk[2] exp_rep[1] exp_sb[0]
  localparam logic [23:0] VEC [NV] = '{
    24'b0000_00_00_1111_11_0_0000_00_000,
    24'b1111_11_00_1111_11_0_0011_11_010,
    24'b1010_10_00_1111_11_0_1010_10_010,
    24'b0100_00_00_1111_11_0_0100_00_000,
    24'b0001_11_11_1111_11_0_0001_00_000,
    24'b0000_11_10_1111_11_0_0000_01_000,
    24'b0000_11_01_1111_11_0_0000_11_000,
    24'b0011_00_00_1110_11_0_0011_00_100,
    24'b1111_11_00_1111_11_0_0000_00_100,
    24'b1111_00_00_1111_11_1_0000_00_000,
    24'b1100_00_00_1111_11_0_1100_00_010,
    24'b0011_11_00_1111_10_0_0011_11_101,
    24'b0000_00_00_1111_11_1_0000_00_001,
    24'b0000_01_00_1111_11_0_0000_01_000,
    24'b0001_00_00_1110_11_1_0001_00_100,
    24'b0000_00_00_1111_11_1_0000_00_000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NLD-1:0] ld_req = '0, ld_acc = '0, ld_gnt;
  logic [NST-1:0] st_req = '0, st_acc = '0, st_gnt;
  logic tso_en = 1'b0, st_inflight = 1'b0, cache_unblock = 1'b0;
  logic cache_blocked, replay, st_blocked;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cache_port_limiter #(.NUM_LD(NLD), .NUM_ST(NST), .LD_BUDGET(2), .ST_BUDGET(2)) uut (
    .clk(clk), .rst(rst), .ld_req(ld_req), .st_req(st_req), .tso_en(tso_en),
    .st_inflight(st_inflight), .ld_acc(ld_acc), .st_acc(st_acc),
    .cache_unblock(cache_unblock), .ld_gnt(ld_gnt), .st_gnt(st_gnt),
    .cache_blocked(cache_blocked), .replay(replay), .st_blocked(st_blocked));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 blocked after reset", 8'(cache_blocked), 8'd0);
    check("R10 replay after reset", 8'(replay), 8'd0);
    check("R10 st_blocked after reset", 8'(st_blocked), 8'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      ld_req = VEC[v][23:20]; st_req = VEC[v][19:18];
      tso_en = VEC[v][17];    st_inflight = VEC[v][16];
      ld_acc = VEC[v][15:12]; st_acc = VEC[v][11:10];
      cache_unblock = VEC[v][9];
      #2;
      check($sformatf("R1 R2 R3 load grants v%0d", v), 8'(ld_gnt), 8'(VEC[v][8:5]));
      check($sformatf("R2 R3 R8 store grants v%0d", v), 8'(st_gnt), 8'(VEC[v][4:3]));
      @(posedge clk);
      #1;
      check($sformatf("R5 R6 blocked v%0d", v), 8'(cache_blocked), 8'(VEC[v][2]));
      check($sformatf("R4 R7 replay v%0d", v), 8'(replay), 8'(VEC[v][1]));
      check($sformatf("R9 st_blocked v%0d", v), 8'(st_blocked), 8'(VEC[v][0]));
    end

    // R10: reset while blocked with store-blocked set
    @(negedge clk);
    cache_unblock = 1'b0; tso_en = 1'b0; st_inflight = 1'b0;
    ld_req = 4'b0011; ld_acc = 4'b1111; st_req = 2'b01; st_acc = 2'b00;
    @(posedge clk); #1;
    check("R5 R9 store reject blocks", 8'({cache_blocked, st_blocked}), 8'b11);
    @(negedge clk);
    ld_req = '0; st_req = '0;
    rst = 1'b1;
    @(posedge clk); #1;
    check("R10 mid-run reset clears flags", 8'({cache_blocked, replay, st_blocked}), 8'b000);
    @(negedge clk);
    rst = 1'b0;
    ld_req = 4'b1111; ld_acc = 4'b1111;
    #2;
    check("R2 R3 grants resume after reset", 8'(ld_gnt), 8'b0011);
    @(posedge clk); #1;
    check("R7 replay after full budget", 8'(replay), 8'd1);
    @(negedge clk);
    ld_req = '0;
    @(posedge clk); #1;
    check("R7 replay is a single pulse", 8'(replay), 8'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule